// File: doc/BRIEF.md
# Prioritized Interrupt Controller Register File

A register-mapped interrupt controller for up to 64 level-sensitive request lines. It samples every line once per clock. It gates the samples with per-source enable bits and gives each source a 4-bit priority. It then drives a single registered interrupt request that carries the number and priority of the winning source. Software reaches it through a plain register read/write port. Enables are never written directly. One alias register sets enable bits and a separate alias clears them. The mode bit works the same way.

The four lowest request lines have two uses, chosen by the mode bit. With the mode bit set, they are four ordinary sources that each have their own enable and priority. With the mode bit clear, the four lines together carry a binary request level. That level is presented as source 0 and uses the level itself as its priority. Raw line status and gated request status can both be read back for polling.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, every enable bit reads 0, every priority register reads 0, the mode bit reads 0 and `irq_o` is low.
- R2: A write to an enable-set register (0x70 for sources 0–31, 0x78 for sources 32–63) sets each enable bit whose data bit is 1 and leaves the others unchanged. Both the set and the clear addresses of a bank read back that bank's enable bits.
- R3: A write to an enable-clear register (0x80 for sources 0–31, 0x88 for sources 32–63) clears each enable bit whose data bit is 1. All ones clears the whole bank.
- R4: Source n below 32 is bit n of the low bank. Source n from 32 upward is bit n−32 of the high bank, whose register sits 8 bytes above the low one.
- R5: Source i has its 4-bit priority in bits [4*(i%8)+3 : 4*(i%8)] of the register at 0x10 + 8*(i/8). The eight priority registers read back what was written.
- R6: Writing data with bit 0 = 1 to 0x00 sets the mode bit, and doing so at 0x08 clears it. Data bit 0 = 0 leaves it unchanged. Both addresses return the mode bit in read bit 0.
- R7: 0x50/0x58 read the line levels sampled one clock earlier, and 0x60/0x68 read those levels ANDed with the enables. Nothing is latched, so a status bit drops when its line drops.
- R8: An enabled, pending source whose priority field is 0 never raises `irq_o`, although its request status bit still reads 1.
- R9: Among enabled pending sources with nonzero priority, the highest priority wins, and a tie goes to the lowest source number. `irq_o` is high exactly when such a source exists. When it is low, `irq_src_o` and `irq_prio_o` are 0.
- R10: With the mode bit 0, lines 3..0 form a level L. Request status bit 0 reads (L≠0 AND enable 0), and bits 3..1 read 0. Source 0 competes with priority L and its priority field is not used. With the mode bit 1, the lines are four individual sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| src_i | input | 64 | Level-sensitive request lines; lines 3..0 are shared with the level mode |
| irq_o | output | 1 | Interrupt request |
| irq_src_o | output | 6 | Winning source number |
| irq_prio_o | output | 4 | Winning priority |

## Verification
A change on `src_i` reaches the status registers after one rising edge and reaches `irq_o`/`irq_src_o`/`irq_prio_o` after two. A register write reaches read-back at the edge that accepts it, and reaches the interrupt outputs at the following edge. The bench drives inputs on falling edges. It waits two falling edges after a line change and one more falling edge after a write before it compares the outputs against a model computed from the requirements. Reads settle combinationally within the same low phase, so nothing is sampled near an active edge.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int REG_W       = 32;
  localparam int PRIO_W      = 4;
  localparam int BANK_SRC    = REG_W;
  localparam int FLD_PER_REG = REG_W / PRIO_W;
  localparam int ADDR_W      = 8;
  localparam int STRIDE      = 8;

  localparam logic [ADDR_W-1:0] A_CTL_SET  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTL_CLR  = 8'h08;
  localparam logic [ADDR_W-1:0] A_PRI_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] A_RAW_BASE = 8'h50;
  localparam logic [ADDR_W-1:0] A_REQ_BASE = 8'h60;
  localparam logic [ADDR_W-1:0] A_ENS_BASE = 8'h70;
  localparam logic [ADDR_W-1:0] A_ENC_BASE = 8'h80;

  function automatic logic [ADDR_W-1:0] reg_addr(input logic [ADDR_W-1:0] base, input int idx);
    return base + ADDR_W'(idx * STRIDE);
  endfunction
endpackage

// File: rtl/pic_regs.sv
`timescale 1ns/1ps
module pic_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic [NUM_SRC-1:0]         raw_i,
  input  logic [NUM_SRC-1:0]         req_i,
  output logic [NUM_SRC-1:0]         en_o,
  output logic [NUM_SRC*PRIO_W-1:0]  prio_o,
  output logic                       indiv_o,
  output logic [REG_W-1:0]           rdata_o
);
  localparam int BANKS     = NUM_SRC / BANK_SRC;
  localparam int PREGS     = NUM_SRC / FLD_PER_REG;
  localparam int PRIO_BITS = NUM_SRC * PRIO_W;

  logic [NUM_SRC-1:0]   en_q, en_d;
  logic [PRIO_BITS-1:0] prio_q, prio_d;
  logic                 indiv_q, indiv_d;

  // next-state: alias writes for enables and mode, plain writes for priorities
  always_comb begin
    en_d    = en_q;
    prio_d  = prio_q;
    indiv_d = indiv_q;
    if (addr == A_CTL_SET && wdata[0]) indiv_d = 1'b1;
    if (addr == A_CTL_CLR && wdata[0]) indiv_d = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr == reg_addr(A_ENS_BASE, b))
        en_d[b*BANK_SRC +: BANK_SRC] = en_q[b*BANK_SRC +: BANK_SRC] | wdata;
      if (addr == reg_addr(A_ENC_BASE, b))
        en_d[b*BANK_SRC +: BANK_SRC] = en_q[b*BANK_SRC +: BANK_SRC] & ~wdata;
    end
    for (int k = 0; k < PREGS; k++) begin
      if (addr == reg_addr(A_PRI_BASE, k))
        prio_d[k*REG_W +: REG_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      prio_q  <= '0;
      indiv_q <= 1'b0;
    end else if (wr_en) begin
      en_q    <= en_d;
      prio_q  <= prio_d;
      indiv_q <= indiv_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr == A_CTL_SET || addr == A_CTL_CLR) rdata_o = {{(REG_W-1){1'b0}}, indiv_q};
    for (int k = 0; k < PREGS; k++) begin
      if (addr == reg_addr(A_PRI_BASE, k)) rdata_o = prio_q[k*REG_W +: REG_W];
    end
    for (int b = 0; b < BANKS; b++) begin
      if (addr == reg_addr(A_RAW_BASE, b)) rdata_o = raw_i[b*BANK_SRC +: BANK_SRC];
      if (addr == reg_addr(A_REQ_BASE, b)) rdata_o = req_i[b*BANK_SRC +: BANK_SRC];
      if (addr == reg_addr(A_ENS_BASE, b) || addr == reg_addr(A_ENC_BASE, b))
        rdata_o = en_q[b*BANK_SRC +: BANK_SRC];
    end
  end

  assign en_o    = en_q;
  assign prio_o  = prio_q;
  assign indiv_o = indiv_q;

  // R2: set alias turns on every written one
  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENS_BASE) |=> ((en_q[BANK_SRC-1:0] & $past(wdata)) == $past(wdata)));
  // R3: clear alias turns off every written one
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENC_BASE) |=> ((en_q[BANK_SRC-1:0] & $past(wdata)) == '0));
  // R6: mode set alias
  a_r6_mode_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL_SET && wdata[0]) |=> indiv_q);
  // R2: without a write the configuration holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_q) && $stable(prio_q) && $stable(indiv_q)));
endmodule

// File: rtl/pic_sample.sv
`timescale 1ns/1ps
module pic_sample
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               indiv_i,
  output logic [NUM_SRC-1:0] raw_o,
  output logic [NUM_SRC-1:0] req_o,
  output logic [PRIO_W-1:0]  lvl_o
);
  logic [NUM_SRC-1:0] raw_q, raw_d;

  always_comb raw_d = src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  // gate with enables; level mode folds the shared lines into source 0
  always_comb begin
    lvl_o = raw_q[PRIO_W-1:0];
    req_o = raw_q & en_i;
    if (!indiv_i) begin
      req_o[PRIO_W-1:0] = '0;
      req_o[0]          = (lvl_o != '0) && en_i[0];
    end
  end

  assign raw_o = raw_q;

  // R10: shared lines above line 0 stay quiet in level mode
  a_r10_enc_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !indiv_i |-> (req_o[PRIO_W-1:1] == '0));
  // R7: no request without its enable
  a_r7_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & ~en_i) == '0);
endmodule

// File: rtl/pic_arbiter.sv
`timescale 1ns/1ps
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic                      indiv_i,
  input  logic [PRIO_W-1:0]         lvl_i,
  output logic                      irq_o,
  output logic [IDX_W-1:0]          src_o,
  output logic [PRIO_W-1:0]         prio_o
);
  logic [PRIO_W-1:0] eff_p [NUM_SRC];
  logic [NUM_SRC-1:0] cand;
  logic [PRIO_W-1:0]  best_p;
  logic [IDX_W-1:0]   best_i;
  logic               irq_q, irq_d;
  logic [IDX_W-1:0]   src_q, src_d;
  logic [PRIO_W-1:0]  lvl_q, lvl_d;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_eff
    if (g == 0) begin : g_shared
      assign eff_p[g] = indiv_i ? prio_i[PRIO_W-1:0] : lvl_i;
    end else begin : g_plain
      assign eff_p[g] = prio_i[g*PRIO_W +: PRIO_W];
    end
    assign cand[g] = req_i[g] && (eff_p[g] != '0);
  end

  // strict compare in ascending order keeps the lowest index on ties
  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && eff_p[i] > best_p) begin
        best_p = eff_p[i];
        best_i = IDX_W'(i);
      end
    end
    irq_d = (best_p != '0);
    src_d = best_i;
    lvl_d = best_p;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      src_q <= '0;
      lvl_q <= '0;
    end else begin
      irq_q <= irq_d;
      src_q <= src_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_o  = irq_q;
  assign src_o  = src_q;
  assign prio_o = lvl_q;

  // R9: any candidate raises the request one edge later
  a_r9_cand_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |=> irq_o);
  // R9: no candidate drops it
  a_r9_none_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(|cand) |=> (!irq_o && src_o == '0 && prio_o == '0));
  // R8: a presented request never carries priority zero
  a_r8_prio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (prio_o != '0));
endmodule

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  input  logic [NUM_SRC-1:0]         src_i,
  output logic                       irq_o,
  output logic [$clog2(NUM_SRC)-1:0] irq_src_o,
  output logic [3:0]                 irq_prio_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [1:0]               rst_sync_q;
  logic                     rst_n_int;
  logic [NUM_SRC-1:0]       en, raw, req;
  logic [NUM_SRC*PRIO_W-1:0] prio;
  logic                     indiv;
  logic [PRIO_W-1:0]        lvl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  pic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .raw_i(raw), .req_i(req), .en_o(en), .prio_o(prio), .indiv_o(indiv), .rdata_o(rdata)
  );

  pic_sample #(.NUM_SRC(NUM_SRC)) u_sample (
    .clk(clk), .rst_n(rst_n_int), .src_i(src_i), .en_i(en), .indiv_i(indiv),
    .raw_o(raw), .req_o(req), .lvl_o(lvl)
  );

  pic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n_int), .req_i(req), .prio_i(prio), .indiv_i(indiv),
    .lvl_i(lvl), .irq_o(irq_o), .src_o(irq_src_o), .prio_o(irq_prio_o)
  );

  // R1: request low in the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n_int) |-> !irq_o);
endmodule

// File: tb/pic_ctrl_bench.sv
`timescale 1ns/1ps
module pic_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [63:0] src_i;
  logic        irq_o;
  logic [5:0]  irq_src_o;
  logic [3:0]  irq_prio_o;

  int n_chk = 0, n_fail = 0;
  logic [3:0]  prio_m [64];
  logic [63:0] en_m;
  logic        mode_m;

  always #5 clk = ~clk;

  pic_ctrl u_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .src_i(src_i), .irq_o(irq_o), .irq_src_o(irq_src_o), .irq_prio_o(irq_prio_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic push_prio(input int k);
    logic [31:0] d;
    for (int f = 0; f < 8; f++) d[4*f +: 4] = prio_m[8*k+f];
    bus_wr(8'(8'h10 + 8*k), d);
  endtask

  // expected {irq, src[5:0], prio[3:0]} from R8/R9/R10
  function automatic logic [10:0] exp_win(input logic [63:0] s, input logic [63:0] e, input logic m);
    logic [3:0] bp = 4'd0;
    logic [5:0] bi = 6'd0;
    for (int i = 0; i < 64; i++) begin
      logic [3:0] p;
      logic       r;
      if (!m && i < 4) begin
        p = s[3:0];
        r = (i == 0) && (s[3:0] != 4'd0) && e[0];
      end else begin
        p = prio_m[i];
        r = s[i] && e[i];
      end
      if (r && p > bp) begin bp = p; bi = 6'(i); end
    end
    return {(bp != 4'd0), bi, bp};
  endfunction

  task automatic chk_out(input string tag);
    chk(tag, {53'd0, irq_o, irq_src_o, irq_prio_o}, {53'd0, exp_win(src_i, en_m, mode_m)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] lf;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; src_i = '0;
    en_m = '0; mode_m = 1'b0;
    for (int i = 0; i < 64; i++) prio_m[i] = 4'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {63'd0, irq_o}, 64'd0);
    bus_rd(8'h00, d); chk("R1 mode", {32'd0, d}, 64'd0);
    bus_rd(8'h70, d); chk("R1 en lo", {32'd0, d}, 64'd0);
    bus_rd(8'h78, d); chk("R1 en hi", {32'd0, d}, 64'd0);
    for (int k = 0; k < 8; k++) begin
      bus_rd(8'(8'h10 + 8*k), d); chk("R1 prio reg", {32'd0, d}, 64'd0);
    end

    // R6 mode aliases
    bus_wr(8'h00, 32'h1);
    bus_rd(8'h00, d); chk("R6 set read", {32'd0, d}, 64'd1);
    bus_rd(8'h08, d); chk("R6 clr addr read", {32'd0, d}, 64'd1);
    bus_wr(8'h08, 32'hFFFF_FFFE);
    bus_rd(8'h00, d); chk("R6 zero bit no effect", {32'd0, d}, 64'd1);
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h00, d); chk("R6 clear", {32'd0, d}, 64'd0);
    bus_wr(8'h00, 32'h1); mode_m = 1'b1;

    // R2 / R3 / R4 enable aliases and bank mapping
    bus_wr(8'h70, 32'hA5A5_0F01);
    bus_rd(8'h70, d); chk("R2 set lo", {32'd0, d}, 64'hA5A5_0F01);
    bus_wr(8'h70, 32'h0);
    bus_rd(8'h70, d); chk("R2 zeros keep", {32'd0, d}, 64'hA5A5_0F01);
    bus_wr(8'h78, 32'h8000_0001);
    bus_rd(8'h78, d); chk("R4 hi bank", {32'd0, d}, 64'h8000_0001);
    bus_rd(8'h88, d); chk("R2 clr addr reads hi", {32'd0, d}, 64'h8000_0001);
    bus_rd(8'h70, d); chk("R4 lo untouched", {32'd0, d}, 64'hA5A5_0F01);
    bus_wr(8'h80, 32'h0000_0F00);
    bus_rd(8'h80, d); chk("R3 partial clear", {32'd0, d}, 64'hA5A5_0001);
    bus_wr(8'h88, 32'hFFFF_FFFF);
    bus_rd(8'h78, d); chk("R3 clear all hi", {32'd0, d}, 64'd0);
    bus_rd(8'h70, d); chk("R3 lo kept", {32'd0, d}, 64'hA5A5_0001);
    bus_wr(8'h80, 32'hFFFF_FFFF);
    bus_rd(8'h70, d); chk("R3 clear all lo", {32'd0, d}, 64'd0);

    // R5 priority packing
    for (int i = 0; i < 64; i++) prio_m[i] = 4'((i*7 + 3) % 16);
    for (int k = 0; k < 8; k++) push_prio(k);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] e;
      for (int f = 0; f < 8; f++) e[4*f +: 4] = prio_m[8*k+f];
      bus_rd(8'(8'h10 + 8*k), d); chk("R5 readback", {32'd0, d}, {32'd0, e});
    end

    // enable everything
    bus_wr(8'h70, 32'hFFFF_FFFF); bus_wr(8'h78, 32'hFFFF_FFFF); en_m = '1;

    // R7 status readback, no latching
    src_i = 64'h0123_4567_89AB_CDEF; settle();
    bus_rd(8'h50, d); chk("R7 raw lo", {32'd0, d}, 64'h89AB_CDEF);
    bus_rd(8'h58, d); chk("R7 raw hi", {32'd0, d}, 64'h0123_4567);
    bus_wr(8'h80, 32'h0000_FFFF); en_m[15:0] = '0;
    bus_rd(8'h60, d); chk("R7 req lo", {32'd0, d}, 64'h89AB_0000);
    bus_rd(8'h68, d); chk("R7 req hi", {32'd0, d}, 64'h0123_4567);
    src_i = '0; settle();
    bus_rd(8'h68, d); chk("R7 drop", {32'd0, d}, 64'd0);
    chk_out("R9 idle");
    bus_wr(8'h70, 32'h0000_FFFF); en_m = '1;

    // R8 priority zero: source 11 has priority 0
    src_i = 64'd1 << 11; settle();
    chk("R8 suppressed", {63'd0, irq_o}, 64'd0);
    bus_rd(8'h60, d); chk("R8 status still set", {32'd0, d}, 64'h0000_0800);

    // R9 tie: sources 5 and 21 both priority 6
    src_i = (64'd1 << 5) | (64'd1 << 21); settle();
    chk("R9 tie lowest", {53'd0, irq_o, irq_src_o, irq_prio_o}, {53'd0, 1'b1, 6'd5, 4'd6});

    // R4 / R5 / R9 single-source sweep with disable
    for (int i = 0; i < 64; i++) begin
      logic [7:0] ba;
      ba = (i < 32) ? 8'h80 : 8'h88;
      src_i = 64'd1 << i; settle();
      chk_out("R9 single");
      bus_wr(ba, 32'd1 << (i % 32)); en_m[i] = 1'b0;
      @(negedge clk);
      chk_out("R4 single disabled");
      bus_wr(ba - 8'h10, 32'd1 << (i % 32)); en_m[i] = 1'b1;
    end

    // R9 mixed patterns
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      src_i = lf & (lf >> 9) & (lf << 3); settle();
      chk_out("R9 pattern");
    end

    // R10 level mode sweep
    bus_wr(8'h08, 32'h1); mode_m = 1'b0;
    prio_m[10] = 4'd8; push_prio(1);
    for (int l = 0; l < 16; l++) begin
      src_i = 64'(l); settle();
      chk_out("R10 level");
      bus_rd(8'h60, d); chk("R10 status", {60'd0, d[3:0]}, {63'd0, l != 0});
      src_i = 64'(l) | (64'd1 << 10); settle();
      chk_out("R10 level vs src10");
    end
    bus_wr(8'h80, 32'h1); en_m[0] = 1'b0;
    src_i = 64'd5; settle();
    chk("R10 gated by enable 0", {63'd0, irq_o}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule